// File: doc/BRIEF.md
# Configuration-Space Indirect BAR Window

This block sits inside a device's configuration space as one capability structure. Through it a driver can reach any register behind any BAR without mapping that BAR. The structure holds four writable fields: a BAR selector, an access size, a byte offset within the BAR, and a four-byte data window. One read-only header dword carries the capability identifier, the next-capability pointer, the structure length in bytes and a structure type code.

Writing or reading the data window starts one transaction on an internal register bus. A write pushes the low bytes of the window out to the selected BAR at the programmed offset. A read fetches that many bytes and stores them in the low bytes of the window before the configuration read completes. A configuration access only completes when the block raises its acknowledge. While a back-end transaction is in flight, the requester is held off until the target answers with ready.

The size must be 1, 2 or 4 and the offset must be a multiple of the size. If either rule is broken, no transaction is issued and a sticky error flag is set. The flag clears only on reset.

Top module: `cfg_bar_window`

## Requirements
- R1: After reset the selector, offset, size and data fields read as zero, `bus_req` and `cfg_ack` are low and `win_err` is low.
- R2: The selector (dword CAP_DW+1, byte 0), offset (dword CAP_DW+2) and size (dword CAP_DW+3) are read-write. Each byte is written only when its `cfg_be` bit is set. Bytes 1 to 3 of the selector dword read as zero.
- R3: The header dword at CAP_DW reads {type code, structure length 20, next pointer, capability id}, from byte 3 down to byte 0. Writes to it are ignored. Dwords outside CAP_DW to CAP_DW+4 read as zero and ignore writes.
- R4: Any access that starts no back-end transaction is acknowledged with a one-cycle `cfg_ack` in the cycle after it is accepted.
- R5: A configuration write to the data window (dword CAP_DW+4) with a legal size and offset first merges the enabled bytes into the window. It then issues exactly one back-end write: `bus_we`=1, `bus_bar` = selector, `bus_addr` = offset, `bus_wdata` = whole window, and `bus_be` = the low size bits set (0001, 0011 or 1111).
- R6: A legal configuration read of the data window issues exactly one back-end read, with `bus_we`=0 and the same address and byte-mask rules. The low size bytes of the window are replaced by the low bytes of `bus_rdata`, the other bytes keep their value, and the configuration read returns the updated window.
- R7: A window access waits for `bus_ready`. `cfg_ack` rises in the cycle after the clock edge at which `bus_req` and `bus_ready` are both high, so a target that waits L cycles gives an access latency of L+2 cycles.
- R8: A window access with a size other than 1, 2 or 4 (including sizes whose upper bits are set) issues no back-end transaction and is acknowledged as in R4. A read returns the window unchanged, a write still merges its bytes, and `win_err` is set.
- R9: A window access whose offset is not a multiple of a legal size behaves as in R8.
- R10: Once set, `win_err` stays high through later legal accesses until reset.
- R11: `bus_req` stays high with stable `bus_we`, `bus_bar`, `bus_addr`, `bus_be` and `bus_wdata` until `bus_ready`. It is low in the following cycle, so at most one transaction is outstanding.
- R12: All fields are little-endian: byte lane k of `cfg_wdata`, `cfg_rdata`, `bus_wdata` and `bus_rdata` (bits 8k+7..8k) maps to byte k of the field. The first bytes of an access are the lowest lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rd | input | 1 | Configuration read request, held until `cfg_ack` |
| cfg_wr | input | 1 | Configuration write request, held until `cfg_ack` |
| cfg_addr | input | CFG_AW | Dword address in configuration space |
| cfg_be | input | 4 | Byte enables of a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, valid while `cfg_ack` is high on a read |
| cfg_ack | output | 1 | One-cycle completion of a configuration access |
| bus_req | output | 1 | Back-end transaction request |
| bus_we | output | 1 | Back-end direction, 1 for write |
| bus_bar | output | BAR_W | Selected BAR |
| bus_addr | output | OFF_W | Byte offset within the BAR |
| bus_be | output | 4 | Right-justified byte mask of the access size |
| bus_wdata | output | 32 | Back-end write data, right-justified |
| bus_rdata | input | 32 | Back-end read data, right-justified |
| bus_ready | input | 1 | Back-end completion |
| win_err | output | 1 | Sticky illegal-size or misaligned flag |

## Verification
The bench programs sizes of 1, 2 and 4 bytes with partial byte enables and checks the merge. A design that shifted the data into lanes by offset, or that overwrote bytes above the size on a read, would return the wrong window. It also uses target wait times of zero and several cycles. A design that released the configuration read before capture would return stale data, and one that dropped or changed `bus_req` early would miss the stability check. Sizes 0, 3, 5 and 0x104 and offsets misaligned for 2 and 4 bytes must produce no transaction and a sticky flag. A design that checked only the low bits of the size, or checked alignment only for 4 bytes, would issue a transaction that should not exist.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

  // bytes in the data window and in one configuration dword
  localparam int unsigned WIN_BYTES = 4;
  localparam int unsigned WIN_W     = 8 * WIN_BYTES;

  // dword index inside the capability structure
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned CAP_DWORDS = 5;
  localparam logic [IDX_W-1:0] IDX_HDR  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_BAR  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_OFF  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_LEN  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DATA = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } win_state_e;

endpackage

// File: rtl/bwin_check.sv
module bwin_check
  import bwin_pkg::*;
#(
  parameter int unsigned OFF_W = 32,
  parameter int unsigned LEN_W = 32
) (
  input  logic [LEN_W-1:0]     len,
  input  logic [OFF_W-1:0]     off,
  output logic                 legal,
  output logic [WIN_BYTES-1:0] mask
);

  localparam int unsigned MAX_LOG = $clog2(WIN_BYTES);

  logic size_hit;
  logic aligned;

  // sizes 2**k for k = 0..MAX_LOG are legal; alignment is checked against the same k
  always_comb begin
    size_hit = 1'b0;
    aligned  = 1'b0;
    mask     = '0;
    for (int k = 0; k <= int'(MAX_LOG); k++) begin
      if (len == LEN_W'(1 << k)) begin
        size_hit = 1'b1;
        mask     = WIN_BYTES'((1 << (1 << k)) - 1);
        aligned  = ((off & OFF_W'((1 << k) - 1)) == '0);
      end
    end
    legal = size_hit && aligned;
  end

endmodule

// File: rtl/bwin_regs.sv
module bwin_regs
  import bwin_pkg::*;
#(
  parameter int unsigned BAR_W     = 8,
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned LEN_W     = 32,
  parameter logic [7:0]  CAP_ID    = 8'h09,
  parameter logic [7:0]  NEXT_PTR  = 8'h00,
  parameter logic [7:0]  TYPE_CODE = 8'h05
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 in_cap,
  input  logic [WIN_BYTES-1:0] wr_be,
  input  logic [WIN_W-1:0]     wr_data,
  input  logic                 ld_en,
  input  logic [WIN_BYTES-1:0] ld_mask,
  input  logic [WIN_W-1:0]     ld_data,
  output logic [BAR_W-1:0]     bar_q,
  output logic [OFF_W-1:0]     off_q,
  output logic [LEN_W-1:0]     len_q,
  output logic [WIN_W-1:0]     data_q,
  output logic [WIN_W-1:0]     rd_word
);

  localparam int unsigned OFF_BYTES = OFF_W / 8;
  localparam int unsigned LEN_BYTES = LEN_W / 8;
  localparam logic [7:0]  CAP_LEN_B = 8'(CAP_DWORDS * 4);

  // ---------------- selector byte ----------------
  logic             bar_en;
  logic [BAR_W-1:0] bar_d;

  always_comb begin
    bar_en = wr_en && (idx == IDX_BAR) && wr_be[0];
    bar_d  = wr_data[BAR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bar_q <= '0;
    else if (bar_en) bar_q <= bar_d;
  end

  // ---------------- offset bytes ----------------
  for (genvar i = 0; i < int'(OFF_BYTES); i++) begin : g_off
    logic       en;
    logic [7:0] d;
    logic [7:0] q;
    always_comb begin
      en = wr_en && (idx == IDX_OFF) && wr_be[i];
      d  = wr_data[8*i +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign off_q[8*i +: 8] = q;
  end

  // ---------------- size bytes ----------------
  for (genvar i = 0; i < int'(LEN_BYTES); i++) begin : g_len
    logic       en;
    logic [7:0] d;
    logic [7:0] q;
    always_comb begin
      en = wr_en && (idx == IDX_LEN) && wr_be[i];
      d  = wr_data[8*i +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign len_q[8*i +: 8] = q;
  end

  // ---------------- data window bytes ----------------
  // a lane is loaded either by a config write or by a back-end read capture
  for (genvar i = 0; i < int'(WIN_BYTES); i++) begin : g_data
    logic       en;
    logic [7:0] d;
    logic [7:0] q;
    always_comb begin
      en = (wr_en && (idx == IDX_DATA) && wr_be[i]) || (ld_en && ld_mask[i]);
      d  = ld_en ? ld_data[8*i +: 8] : wr_data[8*i +: 8];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end
    assign data_q[8*i +: 8] = q;
  end

  // ---------------- read mux ----------------
  always_comb begin
    rd_word = '0;
    if (in_cap) begin
      case (idx)
        IDX_HDR:  rd_word = {TYPE_CODE, CAP_LEN_B, NEXT_PTR, CAP_ID};
        IDX_BAR:  rd_word = WIN_W'(bar_q);
        IDX_OFF:  rd_word = WIN_W'(off_q);
        IDX_LEN:  rd_word = WIN_W'(len_q);
        IDX_DATA: rd_word = data_q;
        default:  rd_word = '0;
      endcase
    end
  end

  // R6
  capture_vs_write_chk : assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !wr_en);

endmodule

// File: rtl/bwin_seq.sv
module bwin_seq
  import bwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rd,
  input  logic cfg_wr,
  input  logic in_cap,
  input  logic win_hit,
  input  logic legal,
  input  logic bus_ready,
  output logic fld_wr_en,
  output logic ld_en,
  output logic cfg_ack,
  output logic rd_op,
  output logic bus_req,
  output logic bus_we,
  output logic win_err
);

  win_state_e state_q, state_d;
  logic       acc;
  logic       we_en, we_d, we_q;
  logic       err_en;

  // next state
  always_comb begin
    acc     = cfg_rd || cfg_wr;
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (acc) state_d = (win_hit && legal) ? ST_BUS : ST_DONE;
      ST_BUS:  if (bus_ready) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    we_en  = (state_q == ST_IDLE) && acc;
    we_d   = cfg_wr;
    err_en = (state_q == ST_IDLE) && acc && win_hit && !legal;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     we_q <= 1'b0;
    else if (we_en) we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_err <= 1'b0;
    else if (err_en) win_err <= 1'b1;
  end

  // outputs
  always_comb begin
    fld_wr_en = (state_q == ST_IDLE) && cfg_wr && in_cap;
    ld_en     = (state_q == ST_BUS) && bus_ready && !we_q;
    cfg_ack   = (state_q == ST_DONE);
    bus_req   = (state_q == ST_BUS);
    bus_we    = we_q;
    rd_op     = !we_q;
  end

  // R4
  ack_single_chk : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ack |=> !cfg_ack);

  // R7
  ack_after_ready_chk : assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready) |=> (cfg_ack && !bus_req));

  // R10
  err_sticky_chk : assert property (@(posedge clk) disable iff (!rst_n)
    win_err |=> win_err);

endmodule

// File: rtl/cfg_bar_window.sv
module cfg_bar_window
  import bwin_pkg::*;
#(
  parameter int unsigned CFG_AW    = 10,
  parameter int unsigned CAP_DW    = 16,
  parameter int unsigned BAR_W     = 8,
  parameter int unsigned OFF_W     = 32,
  parameter int unsigned LEN_W     = 32,
  parameter logic [7:0]  CAP_ID    = 8'h09,
  parameter logic [7:0]  NEXT_PTR  = 8'h00,
  parameter logic [7:0]  TYPE_CODE = 8'h05
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_rd,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [WIN_BYTES-1:0] cfg_be,
  input  logic [WIN_W-1:0]     cfg_wdata,
  output logic [WIN_W-1:0]     cfg_rdata,
  output logic                 cfg_ack,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [BAR_W-1:0]     bus_bar,
  output logic [OFF_W-1:0]     bus_addr,
  output logic [WIN_BYTES-1:0] bus_be,
  output logic [WIN_W-1:0]     bus_wdata,
  input  logic [WIN_W-1:0]     bus_rdata,
  input  logic                 bus_ready,
  output logic                 win_err
);

  localparam logic [CFG_AW-1:0] CAP_LO = CFG_AW'(CAP_DW);
  localparam logic [CFG_AW-1:0] CAP_HI = CFG_AW'(CAP_DW + CAP_DWORDS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  // address decode
  logic             in_cap;
  logic [IDX_W-1:0] idx;
  logic             win_hit;

  always_comb begin
    in_cap  = (cfg_addr >= CAP_LO) && (cfg_addr < CAP_HI);
    idx     = IDX_W'(cfg_addr - CAP_LO);
    win_hit = in_cap && (idx == IDX_DATA);
  end

  logic [BAR_W-1:0]     bar_q;
  logic [OFF_W-1:0]     off_q;
  logic [LEN_W-1:0]     len_q;
  logic [WIN_W-1:0]     data_q;
  logic [WIN_W-1:0]     rd_word;
  logic                 legal;
  logic [WIN_BYTES-1:0] mask;
  logic                 fld_wr_en;
  logic                 ld_en;
  logic                 rd_op;

  bwin_check #(
    .OFF_W (OFF_W),
    .LEN_W (LEN_W)
  ) u_check (
    .len   (len_q),
    .off   (off_q),
    .legal (legal),
    .mask  (mask)
  );

  bwin_regs #(
    .BAR_W     (BAR_W),
    .OFF_W     (OFF_W),
    .LEN_W     (LEN_W),
    .CAP_ID    (CAP_ID),
    .NEXT_PTR  (NEXT_PTR),
    .TYPE_CODE (TYPE_CODE)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (fld_wr_en),
    .idx     (idx),
    .in_cap  (in_cap),
    .wr_be   (cfg_be),
    .wr_data (cfg_wdata),
    .ld_en   (ld_en),
    .ld_mask (mask),
    .ld_data (bus_rdata),
    .bar_q   (bar_q),
    .off_q   (off_q),
    .len_q   (len_q),
    .data_q  (data_q),
    .rd_word (rd_word)
  );

  bwin_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .in_cap    (in_cap),
    .win_hit   (win_hit),
    .legal     (legal),
    .bus_ready (bus_ready),
    .fld_wr_en (fld_wr_en),
    .ld_en     (ld_en),
    .cfg_ack   (cfg_ack),
    .rd_op     (rd_op),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .win_err   (win_err)
  );

  // back-end fields come straight from storage; they cannot change while busy
  always_comb begin
    bus_bar   = bar_q;
    bus_addr  = off_q;
    bus_be    = mask;
    bus_wdata = data_q;
    cfg_rdata = (cfg_ack && rd_op) ? rd_word : '0;
  end

  // R11
  bus_hold_chk : assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_be) && $stable(bus_wdata)
                                 && $stable(bus_bar)));

  // R8, R9
  bus_legal_chk : assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req |-> (legal && $countones(bus_be) != 0));

endmodule

// File: tb/cfg_bar_window_tb.sv
module cfg_bar_window_tb;

  localparam logic [9:0] A_HDR  = 10'd16;
  localparam logic [9:0] A_BAR  = 10'd17;
  localparam logic [9:0] A_OFF  = 10'd18;
  localparam logic [9:0] A_LEN  = 10'd19;
  localparam logic [9:0] A_DATA = 10'd20;

  logic        clk;
  logic        rst_n;
  logic        cfg_rd, cfg_wr;
  logic [9:0]  cfg_addr;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        cfg_ack;
  logic        bus_req, bus_we;
  logic [7:0]  bus_bar;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic        win_err;

  cfg_bar_window u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_ack(cfg_ack), .bus_req(bus_req),
    .bus_we(bus_we), .bus_bar(bus_bar), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .win_err(win_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;

  // last observed access
  logic [31:0] rd_res;
  int          cycles, ntx;
  logic        o_we;
  logic [7:0]  o_bar;
  logic [31:0] o_addr, o_wd;
  logic [3:0]  o_be;
  logic        o_unstable;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old,
                                        input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cfg_rd = 0; cfg_wr = 0; cfg_addr = '0; cfg_be = '0;
    cfg_wdata = '0; bus_rdata = '0; bus_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_acc(input bit wr, input logic [9:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input int lat, input logic [31:0] brd);
    int  waitc = 0;
    bit  done  = 0;
    @(negedge clk);
    cfg_rd = !wr; cfg_wr = wr; cfg_addr = addr; cfg_be = be; cfg_wdata = wd;
    cycles = 0; ntx = 0; o_unstable = 0; rd_res = 'x;
    while (!done && cycles < 64) begin
      @(negedge clk);
      cycles++;
      bus_ready = 0;
      if (cfg_ack) begin
        rd_res = cfg_rdata;
        cfg_rd = 0; cfg_wr = 0;
        done = 1;
      end else if (bus_req) begin
        if (waitc == 0) begin
          o_we = bus_we; o_bar = bus_bar; o_addr = bus_addr;
          o_be = bus_be; o_wd = bus_wdata;
        end else if (o_we !== bus_we || o_bar !== bus_bar || o_addr !== bus_addr ||
                     o_be !== bus_be || o_wd !== bus_wdata) begin
          o_unstable = 1;
        end
        if (waitc == lat) begin
          bus_ready = 1; bus_rdata = brd; ntx++;
        end
        waitc++;
      end
    end
    if (!done) check(0, "R7", "access never acknowledged", 32'(cycles), 32'd0);
  endtask

  task automatic wr32(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
    do_acc(1'b1, a, be, d, 0, 32'h0);
  endtask

  task automatic rd32(input logic [9:0] a);
    do_acc(1'b0, a, 4'h0, 32'h0, 0, 32'h0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    check(bus_req === 1'b0, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
    check(cfg_ack === 1'b0, "R1", "cfg_ack after reset", 32'(cfg_ack), 32'd0);
    check(win_err === 1'b0, "R1", "win_err after reset", 32'(win_err), 32'd0);
    rd32(A_BAR); check(rd_res === 32'h0, "R1", "selector reset", rd_res, 32'h0);
    rd32(A_OFF); check(rd_res === 32'h0, "R1", "offset reset", rd_res, 32'h0);
    rd32(A_LEN); check(rd_res === 32'h0, "R1", "size reset", rd_res, 32'h0);
  endtask

  task automatic t_fields();
    do_reset();
    wr32(A_BAR, 4'hF, 32'hA5A5_A5C3);
    check(cycles == 1, "R4", "field write latency", 32'(cycles), 32'd1);
    rd32(A_BAR);
    check(rd_res === 32'h0000_00C3, "R2", "selector readback", rd_res, 32'h0000_00C3);
    check(cycles == 1 && ntx == 0, "R4", "field read latency", 32'(cycles), 32'd1);
    wr32(A_OFF, 4'hF, 32'h1234_5678);
    wr32(A_OFF, 4'b0101, 32'hAABB_CCDD);
    rd32(A_OFF);
    check(rd_res === 32'h12BB_56DD, "R2", "offset byte enables", rd_res, 32'h12BB_56DD);
    wr32(A_LEN, 4'b0010, 32'h0000_0700);
    rd32(A_LEN);
    check(rd_res === 32'h0000_0700, "R12", "size lane 1 maps to byte 1", rd_res, 32'h0000_0700);
  endtask

  task automatic t_header();
    do_reset();
    rd32(A_HDR);
    check(rd_res === 32'h0514_0009, "R3", "header value", rd_res, 32'h0514_0009);
    wr32(A_HDR, 4'hF, 32'hFFFF_FFFF);
    rd32(A_HDR);
    check(rd_res === 32'h0514_0009, "R3", "header after write", rd_res, 32'h0514_0009);
    wr32(10'd15, 4'hF, 32'hFFFF_FFFF);
    check(cycles == 1 && ntx == 0, "R4", "outside write ack", 32'(cycles), 32'd1);
    rd32(10'd15);
    check(rd_res === 32'h0, "R3", "outside below reads zero", rd_res, 32'h0);
    rd32(10'd21);
    check(rd_res === 32'h0, "R3", "outside above reads zero", rd_res, 32'h0);
  endtask

  task automatic t_win_write();
    do_reset();
    wr32(A_BAR, 4'h1, 32'h3);
    wr32(A_OFF, 4'hF, 32'h12);
    wr32(A_LEN, 4'hF, 32'h2);
    do_acc(1'b1, A_DATA, 4'hF, 32'hDEAD_BEEF, 0, 32'h0);
    check(ntx == 1, "R5", "one write transaction", 32'(ntx), 32'd1);
    check(o_we === 1'b1 && o_bar === 8'h3, "R5", "write dir/bar", {23'b0, o_we, o_bar}, 32'h103);
    check(o_addr === 32'h12, "R5", "write address", o_addr, 32'h12);
    check(o_be === 4'b0011, "R5", "size 2 mask", 32'(o_be), 32'h3);
    check(o_wd === 32'hDEAD_BEEF, "R12", "write data lanes", o_wd, 32'hDEAD_BEEF);
    check(cycles == 2, "R7", "zero-wait write latency", 32'(cycles), 32'd2);
    wr32(A_LEN, 4'hF, 32'h1);
    wr32(A_OFF, 4'hF, 32'h13);
    do_acc(1'b1, A_DATA, 4'b0010, 32'h0000_5500, 4, 32'h0);
    check(o_wd === 32'hDEAD_55EF, "R5", "merged write data", o_wd, 32'hDEAD_55EF);
    check(o_be === 4'b0001 && o_addr === 32'h13, "R5", "size 1 mask/addr", {o_be, o_addr[27:0]}, 32'h1000_0013);
    check(cycles == 6 && ntx == 1, "R7", "wait-4 write latency", 32'(cycles), 32'd6);
    check(!o_unstable, "R11", "request held stable", 32'(o_unstable), 32'd0);
    check(bus_req === 1'b0, "R11", "request dropped after ready", 32'(bus_req), 32'd0);
  endtask

  task automatic t_win_read();
    logic [31:0] exp;
    do_reset();
    wr32(A_BAR, 4'h1, 32'h1);
    wr32(A_LEN, 4'hF, 32'h4);
    wr32(A_OFF, 4'hF, 32'h0);
    do_acc(1'b1, A_DATA, 4'hF, 32'h1122_3344, 0, 32'h0);
    wr32(A_LEN, 4'hF, 32'h1);
    wr32(A_OFF, 4'hF, 32'h7);
    exp = merge(32'h1122_3344, 32'hAABB_CCDD, 4'b0001);
    do_acc(1'b0, A_DATA, 4'h0, 32'h0, 0, 32'hAABB_CCDD);
    check(rd_res === exp, "R6", "size 1 read merge", rd_res, exp);
    check(ntx == 1 && o_we === 1'b0 && o_addr === 32'h7, "R6", "read transaction", o_addr, 32'h7);
    wr32(A_LEN, 4'hF, 32'h2);
    wr32(A_OFF, 4'hF, 32'h6);
    exp = merge(exp, 32'h9988_7766, 4'b0011);
    do_acc(1'b0, A_DATA, 4'h0, 32'h0, 3, 32'h9988_7766);
    check(rd_res === exp, "R6", "size 2 read merge", rd_res, exp);
    check(cycles == 5, "R7", "wait-3 read latency", 32'(cycles), 32'd5);
    wr32(A_LEN, 4'hF, 32'h4);
    wr32(A_OFF, 4'hF, 32'h8);
    do_acc(1'b0, A_DATA, 4'h0, 32'h0, 1, 32'h0102_0304);
    check(rd_res === 32'h0102_0304, "R12", "size 4 read lanes", rd_res, 32'h0102_0304);
    check(o_be === 4'hF, "R6", "size 4 mask", 32'(o_be), 32'hF);
  endtask

  task automatic t_bad_len();
    logic [31:0] lens [4] = '{32'h3, 32'h5, 32'h0, 32'h104};
    do_reset();
    wr32(A_OFF, 4'hF, 32'h0);
    do_acc(1'b1, A_DATA, 4'hF, 32'hCAFE_F00D, 0, 32'h0);  // size 0: no tx, bytes stored
    check(ntx == 0 && cycles == 1, "R8", "size 0 write suppressed", 32'(ntx), 32'd0);
    check(win_err === 1'b1, "R8", "error flag set", 32'(win_err), 32'd1);
    for (int i = 0; i < 4; i++) begin
      wr32(A_LEN, 4'hF, lens[i]);
      do_acc(1'b0, A_DATA, 4'h0, 32'h0, 0, 32'h5555_5555);
      check(ntx == 0, "R8", "illegal size read suppressed", lens[i], 32'd0);
      check(rd_res === 32'hCAFE_F00D, "R8", "window unchanged", rd_res, 32'hCAFE_F00D);
    end
  endtask

  task automatic t_misalign();
    do_reset();
    wr32(A_LEN, 4'hF, 32'h4);
    wr32(A_OFF, 4'hF, 32'h2);
    do_acc(1'b1, A_DATA, 4'hF, 32'h0BAD_0BAD, 0, 32'h0);
    check(ntx == 0 && cycles == 1, "R9", "size 4 offset 2 suppressed", 32'(ntx), 32'd0);
    check(win_err === 1'b1, "R9", "error flag set", 32'(win_err), 32'd1);
    wr32(A_LEN, 4'hF, 32'h2);
    wr32(A_OFF, 4'hF, 32'h5);
    do_acc(1'b0, A_DATA, 4'h0, 32'h0, 0, 32'h7777_7777);
    check(ntx == 0, "R9", "size 2 offset 5 suppressed", 32'(ntx), 32'd0);
    check(rd_res === 32'h0BAD_0BAD, "R9", "window unchanged", rd_res, 32'h0BAD_0BAD);
  endtask

  task automatic t_sticky();
    // continues from the misaligned state: flag is set
    wr32(A_OFF, 4'hF, 32'h4);
    do_acc(1'b0, A_DATA, 4'h0, 32'h0, 0, 32'h0000_1234);
    check(ntx == 1, "R10", "legal access still runs", 32'(ntx), 32'd1);
    check(win_err === 1'b1, "R10", "flag stays after legal access", 32'(win_err), 32'd1);
    do_reset();
    check(win_err === 1'b0, "R10", "flag cleared by reset", 32'(win_err), 32'd0);
  endtask

  initial begin
    t_reset();
    t_fields();
    t_header();
    t_win_write();
    t_win_read();
    t_bad_len();
    t_misalign();
    t_sticky();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule